// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller

This block collects eight interrupt request lines and presents one active-high interrupt to a processor. It records requests as pending, lets software block any line with a mask bit, and picks the winner by fixed priority, with line 0 the most urgent. A request only interrupts the processor if it outranks every level already being serviced, so handlers can nest. The processor answers with two acknowledge pulses. The first moves the winning level into the in-service set. The second returns a vector byte on the data output.

Software talks to the block through a small host port: chip select, read and write strobes, a one-bit address and an 8-bit write bus. Before the block raises any interrupt it takes a four-word setup sequence. That sequence fixes the vector base, the vector spacing (4 or 8), the automatic end-of-service option, which lines are level-sensitive, and which lines have a downstream controller behind them. After setup, single command words change the mask, select which status register is read, and retire the in-service level. During an acknowledge, a 3-bit cascade code names the level being served if a downstream controller sits on that line.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `int_o`, `data_o` and `cas_o` are 0. No interrupt is raised until the setup sequence has completed.
- R2: A write to address 0 with bit 4 set starts setup. It clears the mask, pending and in-service registers. It also latches spacing from bit 2 (1 = 4, 0 = 8) and automatic end-of-service from bit 1. The next three writes to address 1 load, in order, the vector base, the level-sensitivity map (bit i = 1 makes line i level-sensitive) and the downstream map. After the third write the block is configured.
- R3: A line in edge mode becomes pending on a low-to-high transition. It drops out of pending if the line falls before it is acknowledged. A line still held high after service does not request again.
- R4: A line in level mode is pending while it is high. If it is still high once its service ends, it requests again.
- R5: Once configured, a write to address 1 loads the mask register, and a set bit stops that line from interrupting. Pending capture still happens for masked lines. A read at address 1 returns the mask.
- R6: `int_o` is high when some unmasked pending line has a lower index than every in-service line. It updates one clock after the registers it depends on.
- R7: On the first acknowledge pulse, the winning level leaves the pending register and enters the in-service register.
- R8: On the second acknowledge pulse, `data_o` becomes (base + index × spacing) modulo 256.
- R9: If no line qualifies at the first pulse, the second pulse returns the vector of level 7 and the in-service register is left unchanged.
- R10: A write to address 0 with bit 4 clear and bit 5 set clears the lowest-index set bit of the in-service register.
- R11: With automatic end-of-service enabled, the served level's in-service bit is cleared at the second pulse.
- R12: A write to address 0 with bit 4 clear and bit 3 set selects the status read at address 0 by bit 0 (0 = pending, 1 = in-service). Pending is selected after setup. Read data appears on `data_o` one clock after the read strobe.
- R13: From the first acknowledge pulse until the second, `cas_o` holds the served index if that line's downstream-map bit is set, and 0 otherwise. It returns to 0 after the second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 8 | Interrupt request lines, index 0 most urgent |
| cs_i | input | 1 | Host port select |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| a0_i | input | 1 | Host address bit |
| wdata_i | input | 8 | Host write data |
| ack_i | input | 1 | Acknowledge pulse from the processor |
| int_o | output | 1 | Interrupt to the processor |
| data_o | output | 8 | Status readback or vector byte |
| cas_o | output | 3 | Downstream controller code during acknowledge |

## Verification
Nesting is the central corner case. A lower-priority request that arrives while a more urgent level is in service must stay silent until an end-of-service command, and a design that compared against the pending set instead of the in-service set would interrupt too early. The edge/level split is exercised on lines held high after service: an edge line that re-requests, or a level line that does not, shows up as a wrong `int_o` after the end-of-service command. The bench also goes after vector arithmetic that wraps past 255, the level-7 vector on an acknowledge with no request, and an end-of-service command that must clear only the most urgent in-service bit when two bits are set.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    INIT_IDLE,
    INIT_BASE,
    INIT_TRIG,
    INIT_CASC
  } init_st_t;

  localparam int CMD_INIT_BIT = 4;
  localparam int CMD_SP4_BIT  = 2;
  localparam int CMD_AEOI_BIT = 1;
  localparam int CMD_EOI_BIT  = 5;
  localparam int CMD_RSEL_BIT = 3;
  localparam int CMD_RSRC_BIT = 0;
endpackage

// File: rtl/pic_trigger.sv
module pic_trigger #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] lvl_i,
  input  logic [NUM_IRQ-1:0] clr_i,
  input  logic               clr_all_i,
  output logic [NUM_IRQ-1:0] pend_o
);
  logic [NUM_IRQ-1:0] irq_q;
  logic [NUM_IRQ-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_i;
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst || clr_all_i)  pend_q[g] <= 1'b0;
      else if (clr_i[g])     pend_q[g] <= 1'b0;
      else if (lvl_i[g])     pend_q[g] <= irq_i[g];
      else                   pend_q[g] <= (pend_q[g] | (irq_i[g] & ~irq_q[g])) & irq_i[g];
    end

    // R3: an edge-mode line only turns pending after a sampled rising transition
    a_r3_edge_needs_rise: assert property (@(posedge clk) disable iff (rst)
      ($rose(pend_q[g]) && !$past(lvl_i[g])) |-> ($past(irq_i[g]) && !$past(irq_q[g])));
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pic_find_first.sv
module pic_find_first #(
  parameter int N     = 8,
  localparam int IW   = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = |vec_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/pic_vector.sv
module pic_vector #(
  parameter int DW = 8,
  parameter int IW = 3
) (
  input  logic [DW-1:0] base_i,
  input  logic [IW-1:0] idx_i,
  input  logic          sp4_i,
  output logic [DW-1:0] vec_o
);
  logic [DW-1:0] idx_w;
  logic [DW-1:0] offs;

  assign idx_w = DW'(idx_i);
  assign offs  = sp4_i ? (idx_w << 2) : (idx_w << 3);
  assign vec_o = base_i + offs;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_IRQ = 8,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               cs_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic               a0_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               ack_i,
  output logic               int_o,
  output logic [DATA_W-1:0]  data_o,
  output logic [IDX_W-1:0]   cas_o
);
  import pic_pkg::*;

  init_st_t           init_st;
  logic               cfg_done;
  logic               sp4_q, aeoi_q, rsel_q;
  logic [DATA_W-1:0]  base_q;
  logic [NUM_IRQ-1:0] lvl_q, slave_q, mask_q, isr_q, isr_nx;
  logic [NUM_IRQ-1:0] pend, clr_vec;
  logic               ack_ph, sel_hit;
  logic [IDX_W-1:0]   sel_idx;
  logic               req_valid, isr_valid, cand_ok;
  logic [IDX_W-1:0]   req_idx, isr_idx;
  logic [DATA_W-1:0]  vec;

  logic host_wr, host_rd, init_cmd, op0_cmd, eoi_cmd, a1_wr, ack1, ack2;
  assign host_wr  = cs_i & wr_i;
  assign host_rd  = cs_i & rd_i;
  assign init_cmd = host_wr & ~a0_i & wdata_i[CMD_INIT_BIT];
  assign op0_cmd  = host_wr & ~a0_i & ~wdata_i[CMD_INIT_BIT];
  assign eoi_cmd  = op0_cmd & cfg_done & wdata_i[CMD_EOI_BIT];
  assign a1_wr    = host_wr & a0_i;
  assign ack1     = ack_i & ~ack_ph & cfg_done;
  assign ack2     = ack_i & ack_ph;

  pic_trigger #(.NUM_IRQ(NUM_IRQ)) u_trig (
    .clk(clk), .rst(rst), .irq_i(irq_i), .lvl_i(lvl_q),
    .clr_i(clr_vec), .clr_all_i(init_cmd), .pend_o(pend)
  );

  pic_find_first #(.N(NUM_IRQ)) u_req_pick (
    .vec_i(pend & ~mask_q), .valid_o(req_valid), .idx_o(req_idx)
  );

  pic_find_first #(.N(NUM_IRQ)) u_isr_pick (
    .vec_i(isr_q), .valid_o(isr_valid), .idx_o(isr_idx)
  );

  pic_vector #(.DW(DATA_W), .IW(IDX_W)) u_vec (
    .base_i(base_q), .idx_i(sel_idx), .sp4_i(sp4_q), .vec_o(vec)
  );

  assign cand_ok = req_valid & (~isr_valid | (req_idx < isr_idx));
  assign clr_vec = (ack1 && cand_ok) ? (NUM_IRQ'(1) << req_idx) : '0;

  always_comb begin
    isr_nx = isr_q;
    if (eoi_cmd && isr_valid)        isr_nx[isr_idx] = 1'b0;
    if (ack2 && aeoi_q && sel_hit)   isr_nx[sel_idx] = 1'b0;
    if (ack1 && cand_ok)             isr_nx[req_idx] = 1'b1;
  end

  // configuration and host command decode
  always_ff @(posedge clk) begin
    if (rst) begin
      init_st  <= INIT_IDLE;
      cfg_done <= 1'b0;
      sp4_q    <= 1'b0;
      aeoi_q   <= 1'b0;
      rsel_q   <= 1'b0;
      base_q   <= '0;
      lvl_q    <= '0;
      slave_q  <= '0;
      mask_q   <= '0;
    end else if (init_cmd) begin
      init_st  <= INIT_BASE;
      cfg_done <= 1'b0;
      sp4_q    <= wdata_i[CMD_SP4_BIT];
      aeoi_q   <= wdata_i[CMD_AEOI_BIT];
      rsel_q   <= 1'b0;
      mask_q   <= '0;
    end else begin
      if (op0_cmd && wdata_i[CMD_RSEL_BIT]) rsel_q <= wdata_i[CMD_RSRC_BIT];
      if (a1_wr) begin
        case (init_st)
          INIT_BASE: begin base_q  <= wdata_i;              init_st <= INIT_TRIG; end
          INIT_TRIG: begin lvl_q   <= wdata_i[NUM_IRQ-1:0]; init_st <= INIT_CASC; end
          INIT_CASC: begin slave_q <= wdata_i[NUM_IRQ-1:0]; init_st <= INIT_IDLE; cfg_done <= 1'b1; end
          default:   if (cfg_done) mask_q <= wdata_i[NUM_IRQ-1:0];
        endcase
      end
    end
  end

  // in-service set, acknowledge sequencing, outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q   <= '0;
      ack_ph  <= 1'b0;
      sel_hit <= 1'b0;
      sel_idx <= '0;
      cas_o   <= '0;
      int_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      isr_q <= init_cmd ? '0 : isr_nx;
      int_o <= cfg_done & cand_ok;
      if (init_cmd) begin
        ack_ph <= 1'b0;
        cas_o  <= '0;
      end else if (ack1) begin
        ack_ph  <= 1'b1;
        sel_hit <= cand_ok;
        sel_idx <= cand_ok ? req_idx : IDX_W'(NUM_IRQ - 1);
        cas_o   <= (cand_ok && slave_q[req_idx]) ? req_idx : '0;
      end else if (ack2) begin
        ack_ph <= 1'b0;
        cas_o  <= '0;
      end
      if (ack2)         data_o <= vec;
      else if (host_rd) data_o <= a0_i ? DATA_W'(mask_q) : (rsel_q ? DATA_W'(isr_q) : DATA_W'(pend));
    end
  end

  // R6: the interrupt line needs an unmasked pending source in a configured block
  a_r6_int_has_source: assert property (@(posedge clk) disable iff (rst)
    int_o |-> $past(cfg_done && |(pend & ~mask_q)));

  // R7: a qualifying first acknowledge puts the winner into service
  a_r7_ack_sets_isr: assert property (@(posedge clk) disable iff (rst)
    (ack1 && cand_ok && !init_cmd) |=> isr_q[$past(req_idx)]);

  // R10: an end-of-service command retires exactly one level
  a_r10_eoi_drops_one: assert property (@(posedge clk) disable iff (rst)
    (eoi_cmd && isr_valid && !ack_i) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

  // R13: the cascade code is non-zero only inside an acknowledge sequence
  a_r13_cas_in_ack: assert property (@(posedge clk) disable iff (rst)
    (cas_o != '0) |-> ack_ph);
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq = '0;
  logic       cs = 0, rd = 0, wr = 0, a0 = 0, ack = 0;
  logic [7:0] wd = '0;
  logic       int_o;
  logic [7:0] data_o;
  logic [2:0] cas_o;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst(rst), .irq_i(irq), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .a0_i(a0), .wdata_i(wd), .ack_i(ack), .int_o(int_o), .data_o(data_o), .cas_o(cas_o)
  );

  function automatic int f_lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 7;
  endfunction

  function automatic logic [7:0] f_vec(input logic [7:0] base, input int idx, input logic sp4);
    return base + 8'(idx * (sp4 ? 4 : 8));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; a0 = a; wd = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; a0 = a;
    @(negedge clk); cs = 0; rd = 0; d = data_o;
  endtask

  task automatic rd_pend(output logic [7:0] d);
    bus_wr(0, 8'h08); bus_rd(0, d);
  endtask

  task automatic rd_isr(output logic [7:0] d);
    bus_wr(0, 8'h09); bus_rd(0, d);
  endtask

  task automatic do_init(input logic sp4, input logic aeoi, input logic [7:0] base,
                         input logic [7:0] lvl, input logic [7:0] slv);
    bus_wr(0, 8'h10 | {5'd0, sp4, aeoi, 1'b0});
    bus_wr(1, base); bus_wr(1, lvl); bus_wr(1, slv);
  endtask

  task automatic do_ack(output logic [7:0] vec, output logic [2:0] cas_mid);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0; cas_mid = cas_o;
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0; vec = data_o;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d, v;
    logic [2:0] c;
    void'($urandom(32'd2024));
    idle(3); rst = 0; @(negedge clk);
    chk("R1 int after reset", int_o, 0);
    chk("R1 data after reset", data_o, 0);
    chk("R1 cas after reset", cas_o, 0);
    irq = 8'h01; idle(4);
    chk("R1 no int before setup", int_o, 0);
    irq = 8'h00; idle(2);

    do_init(0, 0, 8'h40, 8'h80, 8'h04);
    bus_rd(1, d); chk("R2 mask cleared by setup", d, 8'h00);
    bus_wr(1, 8'hA5); bus_rd(1, d); chk("R5 mask readback", d, 8'hA5);
    bus_wr(1, 8'h00);

    irq[3] = 1; idle(3);
    chk("R6 int for line 3", int_o, 1);
    do_ack(v, c);
    chk("R8 vector line 3 spacing 8", v, 8'h58);
    chk("R13 no cascade code for plain line", c, 0);
    rd_isr(d); chk("R7 isr holds line 3", d, 8'h08);
    rd_pend(d); chk("R12 pending cleared by ack", d, 8'h00);
    chk("R7 int drops after ack", int_o, 0);

    irq[5] = 1; idle(3);
    chk("R6 lower level held off by service", int_o, 0);
    rd_pend(d); chk("R12 pending shows line 5", d, 8'h20);
    irq[1] = 1; idle(3);
    chk("R6 higher level nests", int_o, 1);
    do_ack(v, c);
    chk("R8 vector line 1", v, 8'h48);
    rd_isr(d); chk("R7 two levels in service", d, 8'h0A);
    bus_wr(0, 8'h20);
    rd_isr(d); chk("R10 eoi clears most urgent only", d, 8'h08);
    idle(2); chk("R6 line 5 still below line 3", int_o, 0);
    bus_wr(0, 8'h20); idle(3);
    chk("R10 second eoi frees line 5", int_o, 1);
    rd_pend(d); chk("R3 held edge lines do not re-request", d, 8'h20);
    do_ack(v, c); chk("R8 vector line 5", v, 8'h68);
    bus_wr(0, 8'h20); irq = 8'h00; idle(3);

    irq[2] = 1; idle(2); irq[2] = 0; idle(3);
    chk("R3 withdrawn edge request no int", int_o, 0);
    rd_pend(d); chk("R3 withdrawn edge request not pending", d, 8'h00);

    irq[7] = 1; idle(3);
    chk("R4 level line interrupts", int_o, 1);
    do_ack(v, c); chk("R8 vector line 7", v, 8'h78);
    idle(3); chk("R4 level in service blocks itself", int_o, 0);
    bus_wr(0, 8'h20); idle(3);
    chk("R4 level re-requests after eoi", int_o, 1);
    do_ack(v, c); bus_wr(0, 8'h20);
    irq[7] = 0; idle(3);
    chk("R4 level drop removes int", int_o, 0);
    rd_pend(d); chk("R4 level drop removes pending", d, 8'h00);

    irq[2] = 1; idle(3);
    do_ack(v, c);
    chk("R13 cascade code for line 2", c, 3'd2);
    chk("R13 cascade code cleared after ack", cas_o, 0);
    bus_wr(0, 8'h20); irq = 8'h00; idle(3);

    do_ack(v, c);
    chk("R9 spurious ack gives level 7 vector", v, 8'h78);
    rd_isr(d); chk("R9 spurious ack leaves isr empty", d, 8'h00);

    bus_wr(1, 8'h10); irq[4] = 1; idle(3);
    chk("R5 masked line no int", int_o, 0);
    rd_pend(d); chk("R5 masked line still pending", d, 8'h10);
    bus_wr(1, 8'h00); idle(3);
    chk("R5 unmask raises int", int_o, 1);
    do_ack(v, c); chk("R8 vector line 4", v, 8'h60);
    bus_wr(0, 8'h20); irq = 8'h00; idle(3);

    bus_wr(0, 8'h16); bus_wr(1, 8'hF0);
    irq[0] = 1; idle(3);
    chk("R2 no int during partial setup", int_o, 0);
    bus_wr(1, 8'h00); bus_wr(1, 8'h00); idle(3);
    chk("R2 int after setup completes", int_o, 1);
    do_ack(v, c); chk("R8 vector line 0 spacing 4", v, 8'hF0);
    rd_isr(d); chk("R11 auto eoi clears isr", d, 8'h00);
    irq = 8'h00; idle(2);
    irq[6] = 1; idle(3);
    do_ack(v, c); chk("R8 vector wraps modulo 256", v, 8'h08);
    rd_isr(d); chk("R11 auto eoi after wrap", d, 8'h00);
    irq = 8'h00; idle(3);

    for (int t = 0; t < 40; t++) begin
      logic [7:0] base, lvl, msk, pat, act;
      logic sp4, aeoi;
      int idx;
      base = 8'($urandom); lvl = 8'($urandom); msk = 8'($urandom);
      pat = 8'($urandom); sp4 = 1'($urandom); aeoi = 1'($urandom);
      if (t % 4 == 0) msk = 8'h00;
      do_init(sp4, aeoi, base, lvl, 8'h00);
      bus_wr(1, msk);
      irq = pat; idle(3);
      act = pat & ~msk;
      chk("R6 random int", int_o, (act != 0));
      rd_pend(d); chk("R12 random pending", d, pat);
      idx = (act != 0) ? f_lowest(act) : 7;
      do_ack(v, c);
      chk("R8 random vector", v, f_vec(base, idx, sp4));
      rd_isr(d);
      chk("R11 random isr after ack", d, (act == 0 || aeoi) ? 8'h00 : (8'h01 << idx));
      if (act != 0) begin
        rd_pend(d);
        chk("R7 random pending after ack", d, lvl[idx] ? pat : (pat & ~(8'h01 << idx)));
      end
      if (!aeoi) begin
        bus_wr(0, 8'h20);
        rd_isr(d); chk("R10 random eoi", d, 8'h00);
      end
      irq = 8'h00; idle(3);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule